// File: doc/BRIEF.md
# Twin-Precision Signed Booth Multiplier

This block multiplies two N-bit two's-complement operands with a radix-4 Booth array and can split that array into two independent half-width signed multiplications. With the mode input low it returns the full 2N-bit signed product. With the mode input high, the lower N output bits carry the product of the operands' lower halves, and the upper N output bits carry the product of their upper halves. Both products come from the same array, which has no additional rows.

Each Booth row is built from its recoded digit and an operand that depends on the mode. In full mode every row sees the whole X. In twin mode, rows that recode the low half of Y see a sign-extended low half of X. Rows that recode the high half of Y see the high half of X shifted into place. The cross terms therefore vanish.

The recoding triple of the first high-half row has its borrow bit cleared, so the upper half of Y is recoded as a number of its own. Sign extension is replaced by one constant row of ones. Every row's two's-complement negation bit enters at that row's least significant position. In twin mode a bias of 2^(N-1) is added and output bit N-1 is inverted, so that a negative low product does not borrow from the high field. An optional output register, on by default, gives one cycle of latency.

Top module: `tpm_mult`

## Requirements
- R1: While rst_ni is low, the registered output p_o is all zeros.
- R2: With twin_i = 0, p_o equals the signed 2N-bit product of x_i and y_i. With OUT_REG = 1 the value appears after the next rising clock edge.
- R3: With twin_i = 1, p_o[N-1:0] equals the signed N-bit product of x_i[N/2-1:0] and y_i[N/2-1:0].
- R4: With twin_i = 1, p_o[2N-1:N] equals the signed N-bit product of x_i[N-1:N/2] and y_i[N-1:N/2].
- R5: In twin mode the two output fields are isolated. The high field does not change when only the low operand halves change, and the low field does not change when only the high halves change.
- R6: The most negative operand values give exact results. In full mode, (-2^(N-1))·(-2^(N-1)) = 2^(2N-2). In twin mode, each half gives 2^(N-2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| twin_i | input | 1 | 0: one N×N product, 1: two N/2×N/2 products |
| x_i | input | N | Multiplicand, two's complement (halves in twin mode) |
| y_i | input | N | Multiplier, two's complement (halves in twin mode) |
| p_o | output | 2N | Product, or {high product, low product} |

## Verification
The checker assumes that x_i, y_i and twin_i are settled at each rising edge. With the default register it also assumes they are held for the whole cycle that the result is attributed to. The isolation property assumes twin_i stays high over the two compared cycles. The bench applies one vector per cycle and changes inputs only at falling edges. It runs an exhaustive sweep at N = 8 in both modes, random operands at N = 16 and N = 32, and directed extreme and isolation sequences that hold twin_i steady.

// File: rtl/tpm_pkg.sv
`timescale 1ns/1ps
package tpm_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_TWIN = 1'b1
  } mode_e;

  // radix-4 digit: magnitude one or two, and sign
  typedef struct packed {
    logic one;
    logic two;
    logic neg;
  } booth_t;
endpackage

// File: rtl/tpm_booth_enc.sv
`timescale 1ns/1ps
module tpm_booth_enc
  import tpm_pkg::*;
(
  input  logic [2:0] trip_i,  // {y[2j+1], y[2j], y[2j-1]}
  output booth_t     dig_o
);
  always_comb begin
    dig_o.one = trip_i[1] ^ trip_i[0];
    dig_o.two = (trip_i == 3'b100) || (trip_i == 3'b011);
    dig_o.neg = trip_i[2] & ~(trip_i[1] & trip_i[0]);
  end
endmodule

// File: rtl/tpm_pp_row.sv
`timescale 1ns/1ps
module tpm_pp_row
  import tpm_pkg::*;
#(
  parameter int N   = 8,
  parameter int ROW = 0
) (
  input  logic [N-1:0]   x_i,
  input  logic           twin_i,
  input  booth_t         dig_i,
  output logic [2*N-1:0] row_o
);
  localparam int H     = N / 2;
  localparam int SHIFT = 2 * ROW;

  logic [N-1:0] opnd;
  logic [N:0]   mag;
  logic [N:0]   flip;

  // twin mode: low rows see sext(x_lo), high rows see x_hi << H; cross terms vanish
  generate
    if (ROW < N / 4) begin : g_lo
      assign opnd = twin_i ? {{H{x_i[H-1]}}, x_i[H-1:0]} : x_i;
    end else begin : g_hi
      assign opnd = twin_i ? {x_i[N-1:H], {H{1'b0}}} : x_i;
    end
  endgenerate

  always_comb begin
    if (dig_i.one)      mag = {opnd[N-1], opnd};
    else if (dig_i.two) mag = {opnd, 1'b0};
    else                mag = '0;
    flip = mag ^ {(N+1){dig_i.neg}};
  end

  // sign bit inverted: row carries +2^N bias, removed by the constant row
  assign row_o = {{(N-1){1'b0}}, ~flip[N], flip[N-1:0]} << SHIFT;
endmodule

// File: rtl/tpm_sum.sv
`timescale 1ns/1ps
module tpm_sum #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] rows_i [N/2],
  input  logic [2*N-1:0] neg_i,
  input  logic           twin_i,
  output logic [2*N-1:0] sum_o
);
  localparam int ROWS = N / 2;

  function automatic logic [2*N-1:0] ones_const();
    logic [2*N-1:0] k;
    k = '0;
    for (int j = 0; j < ROWS; j++)
      k = k - ({{(2*N-1){1'b0}}, 1'b1} << (N + 2*j));
    return k;
  endfunction

  localparam logic [2*N-1:0] SEXT_K   = ones_const();
  localparam logic [2*N-1:0] TWIN_BIAS = {{(2*N-1){1'b0}}, 1'b1} << (N - 1);

  logic [2*N-1:0] acc;

  always_comb begin
    acc = SEXT_K + neg_i;
    if (twin_i) acc = acc + TWIN_BIAS;  // keeps low field non-negative
    for (int j = 0; j < ROWS; j++)
      acc = acc + rows_i[j];
  end

  assign sum_o = acc;
endmodule

// File: rtl/tpm_mult.sv
`timescale 1ns/1ps
module tpm_mult
  import tpm_pkg::*;
#(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           twin_i,
  input  logic [N-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  output logic [2*N-1:0] p_o
);
  localparam int ROWS = N / 2;
  localparam int QROW = N / 4;  // first row of the high half

  booth_t         dig  [ROWS];
  logic [2*N-1:0] rows [ROWS];
  logic [2*N-1:0] neg_vec;
  logic [2*N-1:0] sum;
  logic [2*N-1:0] res;

  generate
    for (genvar j = 0; j < ROWS; j++) begin : g_row
      logic y_prev;
      if (j == 0) begin : g_first
        assign y_prev = 1'b0;
      end else if (j == QROW) begin : g_split
        assign y_prev = y_i[2*j-1] & ~twin_i;  // cut recoding at the half boundary
      end else begin : g_mid
        assign y_prev = y_i[2*j-1];
      end

      tpm_booth_enc u_enc (
        .trip_i ({y_i[2*j+1], y_i[2*j], y_prev}),
        .dig_o  (dig[j])
      );

      tpm_pp_row #(.N(N), .ROW(j)) u_row (
        .x_i    (x_i),
        .twin_i (twin_i),
        .dig_i  (dig[j]),
        .row_o  (rows[j])
      );

      assign neg_vec[2*j]   = dig[j].neg;
      assign neg_vec[2*j+1] = 1'b0;
    end
  endgenerate

  assign neg_vec[2*N-1:N] = '0;

  tpm_sum #(.N(N)) u_sum (
    .rows_i (rows),
    .neg_i  (neg_vec),
    .twin_i (twin_i),
    .sum_o  (sum)
  );

  // undo the twin bias on the low field
  assign res = {sum[2*N-1:N], sum[N-1] ^ twin_i, sum[N-2:0]};

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_o <= '0;
        else         p_o <= res;
      end
    end else begin : g_comb
      assign p_o = res;
    end
  endgenerate
endmodule

// File: rtl/tpm_mult_chk.sv
`timescale 1ns/1ps
module tpm_mult_chk #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           twin_i,
  input logic [N-1:0]   x_i,
  input logic [N-1:0]   y_i,
  input logic [2*N-1:0] p_o
);
  localparam int H = N / 2;

  logic [2*N-1:0] ref_full;
  logic [N-1:0]   ref_lo;
  logic [N-1:0]   ref_hi;
  logic [N-1:0]   hi_ops;
  logic [N-1:0]   lo_ops;
  logic [1:0]     age_q;

  assign ref_full = $signed({{N{x_i[N-1]}}, x_i}) * $signed({{N{y_i[N-1]}}, y_i});
  assign ref_lo   = $signed({{H{x_i[H-1]}}, x_i[H-1:0]}) * $signed({{H{y_i[H-1]}}, y_i[H-1:0]});
  assign ref_hi   = $signed({{H{x_i[N-1]}}, x_i[N-1:H]}) * $signed({{H{y_i[N-1]}}, y_i[N-1:H]});
  assign hi_ops   = {x_i[N-1:H], y_i[N-1:H]};
  assign lo_ops   = {x_i[H-1:0], y_i[H-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  generate
    if (OUT_REG) begin : g_reg
      assert_reset_zero_R1: assert property (@(posedge clk_i)
        !rst_ni |-> p_o == '0);
      assert_full_product_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q != 2'd0) && !$past(twin_i) |-> p_o == $past(ref_full));
      assert_twin_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q != 2'd0) && $past(twin_i) |-> p_o[N-1:0] == $past(ref_lo));
      assert_twin_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q != 2'd0) && $past(twin_i) |-> p_o[2*N-1:N] == $past(ref_hi));
      assert_high_isolated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) && $past(twin_i) && $past(twin_i, 2) && ($past(hi_ops) == $past(hi_ops, 2))
        |-> p_o[2*N-1:N] == $past(p_o[2*N-1:N]));
      assert_low_isolated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) && $past(twin_i) && $past(twin_i, 2) && ($past(lo_ops) == $past(lo_ops, 2))
        |-> p_o[N-1:0] == $past(p_o[N-1:0]));
    end else begin : g_comb
      assert_full_product_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !twin_i |-> p_o == ref_full);
      assert_twin_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        twin_i |-> p_o[N-1:0] == ref_lo);
      assert_twin_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        twin_i |-> p_o[2*N-1:N] == ref_hi);
      assert_high_isolated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q != 2'd0) && twin_i && $past(twin_i) && $stable(hi_ops)
        |-> $stable(p_o[2*N-1:N]));
    end
  endgenerate
endmodule

bind tpm_mult tpm_mult_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .twin_i (twin_i),
  .x_i    (x_i),
  .y_i    (y_i),
  .p_o    (p_o)
);

// File: tb/tb_tpm_mult.sv
`timescale 1ns/1ps
module tb_tpm_mult;
  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  always #2.5 clk = ~clk;

  logic        t8, t16, t32;
  logic [7:0]  x8, y8;
  logic [15:0] x16, y16;
  logic [31:0] x32, y32;
  logic [15:0] p8;
  logic [31:0] p16;
  logic [63:0] p32;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  tpm_mult #(.N(8))  dut   (.clk_i(clk), .rst_ni(rst_ni), .twin_i(t8),  .x_i(x8),  .y_i(y8),  .p_o(p8));
  tpm_mult #(.N(16)) dut16 (.clk_i(clk), .rst_ni(rst_ni), .twin_i(t16), .x_i(x16), .y_i(y16), .p_o(p16));
  tpm_mult #(.N(32)) dut32 (.clk_i(clk), .rst_ni(rst_ni), .twin_i(t32), .x_i(x32), .y_i(y32), .p_o(p32));

  function automatic longint sx(input logic [63:0] v, input int w);
    longint r;
    r = $signed(v << (64 - w));
    return r >>> (64 - w);
  endfunction

  function automatic logic [63:0] msk(input logic [63:0] v, input int n);
    if (n >= 64) return v;
    return v & ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [63:0] ref_p(input int w, input logic [63:0] x, input logic [63:0] y, input bit t);
    int h;
    logic [63:0] lo, hi;
    h = w / 2;
    if (!t) return msk(64'(sx(x, w) * sx(y, w)), 2 * w);
    lo = msk(64'(sx(x, h) * sx(y, h)), w);
    hi = msk(64'(sx(x >> h, h) * sx(y >> h, h)), w);
    return (hi << w) | lo;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmp_dut(input string full_req, input int w, input logic [63:0] x,
                         input logic [63:0] y, input bit t, input logic [63:0] p);
    logic [63:0] e;
    e = ref_p(w, x, y, t);
    if (!t) chk(full_req, p, e);
    else begin
      chk("R3", msk(p, w), msk(e, w));
      chk("R4", p >> w, e >> w);
    end
  endtask

  // inputs already set at a falling edge; result is registered at the next rising edge
  task automatic apply(input string full_req);
    @(negedge clk);
    cmp_dut(full_req, 8,  64'(x8),  64'(y8),  t8,  64'(p8));
    cmp_dut(full_req, 16, 64'(x16), 64'(y16), t16, 64'(p16));
    cmp_dut(full_req, 32, 64'(x32), 64'(y32), t32, p32);
  endtask

  task automatic rand_wide();
    x16 = 16'($urandom()); y16 = 16'($urandom()); t16 = 1'($urandom());
    x32 = $urandom();      y32 = $urandom();      t32 = 1'($urandom());
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] hold_hi;
    logic [15:0] hold_lo;
    void'($urandom(32'd7319));
    t8 = 0; x8 = 8'h5a; y8 = 8'ha5;
    t16 = 0; x16 = '1; y16 = '1;
    t32 = 0; x32 = '1; y32 = '1;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R1: output held at zero in reset
    chk("R1", 64'(p8), 64'd0);
    chk("R1", 64'(p16), 64'd0);
    chk("R1", p32, 64'd0);
    rst_ni = 1'b1;

    // R6: extreme operands, full and twin
    t8 = 0; x8 = 8'h80; y8 = 8'h80;
    t16 = 0; x16 = 16'h8000; y16 = 16'h8000;
    t32 = 0; x32 = 32'h8000_0000; y32 = 32'h8000_0000;
    apply("R6");
    chk("R6", 64'(p8), 64'h4000);
    t8 = 1; x8 = 8'h88; y8 = 8'h88;
    t16 = 1; x16 = 16'h8080; y16 = 16'h8080;
    t32 = 1; x32 = 32'h8000_8000; y32 = 32'h8000_8000;
    apply("R6");
    chk("R6", 64'(p8), 64'h4040);
    t8 = 0; x8 = 8'h80; y8 = 8'h7f;
    t16 = 1; x16 = 16'h807f; y16 = 16'h7f80;
    t32 = 0; x32 = 32'h7fff_ffff; y32 = 32'h8000_0000;
    apply("R6");

    // R5: high field unaffected by low-half changes, and the reverse
    t16 = 1; x16 = 16'h8000; y16 = 16'h7f00;
    apply("R5");
    hold_hi = p16 >> 16;
    for (int i = 0; i < 40; i++) begin
      x16[7:0] = 8'($urandom()); y16[7:0] = 8'($urandom());
      apply("R5");
      chk("R5", 64'(p16 >> 16), 64'(hold_hi));
    end
    x16 = 16'h0080; y16 = 16'h0081;
    apply("R5");
    hold_lo = p16[15:0];
    for (int i = 0; i < 40; i++) begin
      x16[15:8] = 8'($urandom()); y16[15:8] = 8'($urandom());
      apply("R5");
      chk("R5", 64'(p16[15:0]), 64'(hold_lo));
    end

    // R2/R3/R4: exhaustive at N=8 in both modes, random at N=16 and N=32
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          t8 = 1'(m); x8 = 8'(a); y8 = 8'(b);
          rand_wide();
          apply("R2");
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule